// File: doc/BRIEF.md
# Rotating Register Rename with Counted-Loop Control

This block turns logical general-register and predicate numbers into physical numbers for a 128-entry, flatly addressed register space. Part of each space is a rotating region; a logical index inside it is offset by a rotating base, wrapped to the region size, and added to the region start. Renaming moves no data. Only the base changes, so a software-pipelined loop finds each value one register further along on the next iteration.

A counted-loop branch strobe drives the rotation. The strobe reads a loop counter and an epilog counter, and from them it decides whether the branch is taken, what the stage predicate becomes, and whether both bases step. Loop bodies therefore need no decrement or compare of their own. Software loads the counters through write ports. The size of the general rotating region comes from an input. The predicate rotating region is fixed by parameter as the upper half of the predicate space.

Top module: `rrot_rename`

## Requirements
- R1: A general index below 32, or at or above 32 plus the effective region size, maps to itself. A predicate index below 64 maps to itself.
- R2: A general index i with 32 <= i < 32+S maps to 32 + ((i-32+B) mod S). B is the general base. S is the effective size: `rot_size` clamped to at most 96, held in a register and therefore used from the clock edge after it is applied. When S is 0, every index passes through.
- R3: A predicate index p with 64 <= p <= 127 maps to 64 + ((p-64+P) mod 64). P is the predicate base.
- R4: A strobe with the loop counter non-zero decrements the loop counter, sets `stage_pred` to 1, rotates both bases and raises `br_taken`.
- R5: A strobe with the loop counter zero and the epilog counter above 1 decrements the epilog counter, sets `stage_pred` to 0, rotates and raises `br_taken`.
- R6: A strobe with the loop counter zero and the epilog counter at 0 or 1 does not rotate and keeps `br_taken` low. It clears `stage_pred` and decrements the epilog counter only if the counter is non-zero.
- R7: Each rotation lowers a base by one, modulo its region size. A value at logical r is then found at logical r+1.
- R8: `br_taken` is combinational. It is high only in a cycle where `br_loop` is high.
- R9: When a counter write and a strobe fall in the same cycle, the strobe decides from the counter values held before that edge, and the written value replaces that counter's update.
- R10: A change in the effective general size clears the general base to 0 at the next edge, and this takes precedence over rotation. The predicate base is unaffected.
- R11: Synchronous reset clears both bases, both counters and `stage_pred`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_loop | input | 1 | Counted-loop branch strobe |
| lc_we | input | 1 | Loop counter write enable |
| lc_wdata | input | 16 | Loop counter write value |
| ec_we | input | 1 | Epilog counter write enable |
| ec_wdata | input | 6 | Epilog counter write value |
| rot_size | input | 7 | Requested general rotating region size |
| gr_log | input | 14 | Two packed logical general indices, port 0 in bits 6:0 |
| pr_log | input | 14 | Two packed logical predicate indices, port 0 in bits 6:0 |
| gr_phys | output | 14 | Physical general indices, same packing |
| pr_phys | output | 14 | Physical predicate indices, same packing |
| br_taken | output | 1 | The strobe in this cycle is taken |
| stage_pred | output | 1 | Rotating stage predicate |

## Verification
The hardest state to reach is a strobe that lands while a counter write is in progress, or while the region size is changing. Both cases need several inputs to line up on one edge. A table of loop shapes steps through the kernel, epilog and exit phases, including the wrap of the base at odd region sizes and at size 1. Directed sequences then line up a loop counter write with a strobe, change the size partway through a rotation, and apply the size clamp and a reset in mid-loop.

// File: rtl/rrot_pkg.sv
package rrot_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_KERNEL = 2'd1,
      PH_DRAIN  = 2'd2,
      PH_EXIT   = 2'd3
   } loop_phase_e;
endpackage

// File: rtl/rrot_xlate.sv
module rrot_xlate #(
   parameter int IW    = 7,
   parameter int SW    = 7,
   parameter int START = 32
) (
   input  logic [IW-1:0] idx,
   input  logic [SW-1:0] size,
   input  logic [SW-1:0] base,
   output logic [IW-1:0] phys
);
   localparam logic [IW:0] START_V = (IW+1)'(START);

   if (SW > IW) begin : g_bad_w
      $error("rrot_xlate: size width exceeds index width");
   end
   if (START >= (1 << IW)) begin : g_bad_s
      $error("rrot_xlate: region start outside index space");
   end

   logic [IW:0] ext_idx;
   logic [IW:0] off;
   logic        in_reg;
   logic [SW:0] sum;
   logic [SW:0] wrapped;

   always_comb begin
      ext_idx = {1'b0, idx};
      off     = ext_idx - START_V;
      in_reg  = (ext_idx >= START_V) && (off < (IW+1)'(size));
      sum     = (SW+1)'(off) + {1'b0, base};
      wrapped = (sum >= {1'b0, size}) ? (sum - {1'b0, size}) : sum;
      phys    = in_reg ? IW'(START_V + (IW+1)'(wrapped)) : idx;
   end
endmodule

// File: rtl/rrot_base.sv
module rrot_base #(
   parameter int SW         = 7,
   parameter bit FIXED      = 1'b0,
   parameter int FIXED_SIZE = 64
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic [SW-1:0] size_in,
   output logic [SW-1:0] base,
   output logic [SW-1:0] size_q
);
   logic          size_chg;
   logic [SW-1:0] base_q;

   if (FIXED) begin : g_fixed
      if (FIXED_SIZE >= (1 << SW)) begin : g_bad
         $error("rrot_base: fixed size does not fit");
      end
      assign size_q   = SW'(FIXED_SIZE);
      assign size_chg = 1'b0;
      logic unused_sz;
      assign unused_sz = ^size_in;
   end else begin : g_prog
      logic [SW-1:0] sz_r;
      always_ff @(posedge clk) begin
         if (rst) sz_r <= '0;
         else     sz_r <= size_in;
      end
      assign size_q   = sz_r;
      assign size_chg = (size_in != sz_r);
   end

   always_ff @(posedge clk) begin
      if (rst)                          base_q <= '0;
      else if (size_chg)                base_q <= '0;
      else if (step && size_q != '0)    base_q <= (base_q == '0) ? size_q - 1'b1 : base_q - 1'b1;
   end

   assign base = base_q;
endmodule

// File: rtl/rrot_loopctl.sv
module rrot_loopctl
   import rrot_pkg::*;
#(
   parameter int LC_W = 16,
   parameter int EC_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            br_loop,
   input  logic            lc_we,
   input  logic [LC_W-1:0] lc_wdata,
   input  logic            ec_we,
   input  logic [EC_W-1:0] ec_wdata,
   output logic            rotate,
   output logic            stage,
   output logic [LC_W-1:0] lc,
   output logic [EC_W-1:0] ec
);
   loop_phase_e     phase;
   logic [LC_W-1:0] lc_q, lc_d;
   logic [EC_W-1:0] ec_q, ec_d;
   logic            stage_q, stage_d;

   always_comb begin
      if (!br_loop)                     phase = PH_IDLE;
      else if (lc_q != '0)              phase = PH_KERNEL;
      else if (ec_q > EC_W'(1))         phase = PH_DRAIN;
      else                              phase = PH_EXIT;

      lc_d    = lc_q;
      ec_d    = ec_q;
      stage_d = stage_q;
      unique case (phase)
         PH_KERNEL: begin
            lc_d    = lc_q - 1'b1;
            stage_d = 1'b1;
         end
         PH_DRAIN: begin
            ec_d    = ec_q - 1'b1;
            stage_d = 1'b0;
         end
         PH_EXIT: begin
            if (ec_q != '0) ec_d = ec_q - 1'b1;
            stage_d = 1'b0;
         end
         default: ;
      endcase
      if (lc_we) lc_d = lc_wdata;
      if (ec_we) ec_d = ec_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lc_q    <= '0;
         ec_q    <= '0;
         stage_q <= 1'b0;
      end else begin
         lc_q    <= lc_d;
         ec_q    <= ec_d;
         stage_q <= stage_d;
      end
   end

   assign rotate = (phase == PH_KERNEL) || (phase == PH_DRAIN);
   assign stage  = stage_q;
   assign lc     = lc_q;
   assign ec     = ec_q;
endmodule

// File: rtl/rrot_rename.sv
module rrot_rename #(
   parameter int GR_N         = 128,
   parameter int GR_ROT_START = 32,
   parameter int GR_ROT_MAX   = 96,
   parameter int PR_N         = 128,
   parameter int PR_ROT_START = 64,
   parameter int NPORT        = 2,
   parameter int LC_W         = 16,
   parameter int EC_W         = 6,
   localparam int GR_IW = $clog2(GR_N),
   localparam int PR_IW = $clog2(PR_N),
   localparam int SZ_W  = $clog2(GR_ROT_MAX + 1),
   localparam int PR_SZ = PR_N - PR_ROT_START,
   localparam int PR_SW = $clog2(PR_SZ + 1)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   br_loop,
   input  logic                   lc_we,
   input  logic [LC_W-1:0]        lc_wdata,
   input  logic                   ec_we,
   input  logic [EC_W-1:0]        ec_wdata,
   input  logic [SZ_W-1:0]        rot_size,
   input  logic [NPORT*GR_IW-1:0] gr_log,
   input  logic [NPORT*PR_IW-1:0] pr_log,
   output logic [NPORT*GR_IW-1:0] gr_phys,
   output logic [NPORT*PR_IW-1:0] pr_phys,
   output logic                   br_taken,
   output logic                   stage_pred
);
   if (GR_ROT_START + GR_ROT_MAX > GR_N) begin : g_bad_gr
      $error("rrot_rename: general rotating region exceeds register count");
   end
   if (PR_ROT_START >= PR_N) begin : g_bad_pr
      $error("rrot_rename: predicate rotating region is empty");
   end
   if (NPORT < 1) begin : g_bad_np
      $error("rrot_rename: need at least one port");
   end

   localparam logic [SZ_W-1:0] MAX_V = SZ_W'(GR_ROT_MAX);

   logic            rotate;
   logic [LC_W-1:0] lc;
   logic [EC_W-1:0] ec;
   logic [SZ_W-1:0] gr_size_eff;
   logic [SZ_W-1:0] gr_base, gr_size_q;
   logic [PR_SW-1:0] pr_base, pr_size_q;

   assign gr_size_eff = (rot_size > MAX_V) ? MAX_V : rot_size;

   rrot_loopctl #(.LC_W(LC_W), .EC_W(EC_W)) u_ctl (
      .clk(clk), .rst(rst), .br_loop(br_loop),
      .lc_we(lc_we), .lc_wdata(lc_wdata),
      .ec_we(ec_we), .ec_wdata(ec_wdata),
      .rotate(rotate), .stage(stage_pred), .lc(lc), .ec(ec)
   );

   rrot_base #(.SW(SZ_W), .FIXED(1'b0), .FIXED_SIZE(0)) u_gr_base (
      .clk(clk), .rst(rst), .step(rotate), .size_in(gr_size_eff),
      .base(gr_base), .size_q(gr_size_q)
   );

   rrot_base #(.SW(PR_SW), .FIXED(1'b1), .FIXED_SIZE(PR_SZ)) u_pr_base (
      .clk(clk), .rst(rst), .step(rotate), .size_in(PR_SW'(PR_SZ)),
      .base(pr_base), .size_q(pr_size_q)
   );

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      rrot_xlate #(.IW(GR_IW), .SW(SZ_W), .START(GR_ROT_START)) u_gx (
         .idx(gr_log[g*GR_IW +: GR_IW]), .size(gr_size_q), .base(gr_base),
         .phys(gr_phys[g*GR_IW +: GR_IW])
      );
      rrot_xlate #(.IW(PR_IW), .SW(PR_SW), .START(PR_ROT_START)) u_px (
         .idx(pr_log[g*PR_IW +: PR_IW]), .size(pr_size_q), .base(pr_base),
         .phys(pr_phys[g*PR_IW +: PR_IW])
      );
   end

   assign br_taken = rotate;
endmodule

// File: rtl/rrot_rename_chk.sv
module rrot_rename_chk #(
   parameter int GR_IW        = 7,
   parameter int SZ_W         = 7,
   parameter int LC_W         = 16,
   parameter int EC_W         = 6,
   parameter int GR_ROT_START = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            br_loop,
   input logic            lc_we,
   input logic            ec_we,
   input logic            br_taken,
   input logic            stage_pred,
   input logic [GR_IW-1:0] gr_log0,
   input logic [GR_IW-1:0] gr_phys0,
   input logic [LC_W-1:0] lc,
   input logic [EC_W-1:0] ec,
   input logic [SZ_W-1:0] gr_base,
   input logic [SZ_W-1:0] gr_size_q,
   input logic [SZ_W-1:0] gr_size_eff
);
   a_r8_taken_needs_strobe: assert property (@(posedge clk) disable iff (rst)
      !br_loop |-> !br_taken);

   a_r4_lc_counts_down: assert property (@(posedge clk) disable iff (rst)
      (br_loop && !lc_we && lc != '0) |=> (lc == $past(lc) - 1'b1));

   a_r4_stage_set: assert property (@(posedge clk) disable iff (rst)
      (br_loop && lc != '0) |=> stage_pred);

   a_r5_ec_counts_down: assert property (@(posedge clk) disable iff (rst)
      (br_loop && !ec_we && lc == '0 && ec > EC_W'(1)) |=> (ec == $past(ec) - 1'b1));

   a_r6_exit_not_taken: assert property (@(posedge clk) disable iff (rst)
      (br_loop && lc == '0 && ec <= EC_W'(1)) |-> !br_taken);

   a_r7_base_steps_down: assert property (@(posedge clk) disable iff (rst)
      (br_taken && gr_size_q != '0 && gr_size_eff == gr_size_q) |=>
      (gr_base == (($past(gr_base) == '0) ? $past(gr_size_q) - 1'b1 : $past(gr_base) - 1'b1)));

   a_r10_resize_clears: assert property (@(posedge clk) disable iff (rst)
      (gr_size_eff != gr_size_q) |=> (gr_base == '0));

   a_r1_low_passthrough: assert property (@(posedge clk) disable iff (rst)
      (gr_log0 < GR_IW'(GR_ROT_START)) |-> (gr_phys0 == gr_log0));
endmodule

bind rrot_rename rrot_rename_chk #(
   .GR_IW(GR_IW), .SZ_W(SZ_W), .LC_W(LC_W), .EC_W(EC_W), .GR_ROT_START(GR_ROT_START)
) u_chk (
   .clk(clk), .rst(rst), .br_loop(br_loop), .lc_we(lc_we), .ec_we(ec_we),
   .br_taken(br_taken), .stage_pred(stage_pred),
   .gr_log0(gr_log[GR_IW-1:0]), .gr_phys0(gr_phys[GR_IW-1:0]),
   .lc(lc), .ec(ec), .gr_base(gr_base), .gr_size_q(gr_size_q),
   .gr_size_eff(gr_size_eff)
);

// File: tb/sim_rrot_rename.sv
`timescale 1ns/1ps
module sim_rrot_rename;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br_loop = 1'b0;
   logic        lc_we = 1'b0;
   logic [15:0] lc_wdata = '0;
   logic        ec_we = 1'b0;
   logic [5:0]  ec_wdata = '0;
   logic [6:0]  rot_size = 7'd96;
   logic [13:0] gr_log = '0;
   logic [13:0] pr_log = '0;
   logic [13:0] gr_phys, pr_phys;
   logic        br_taken, stage_pred;

   always #2 clk = ~clk;

   rrot_rename u0 (
      .clk(clk), .rst(rst), .br_loop(br_loop), .lc_we(lc_we), .lc_wdata(lc_wdata),
      .ec_we(ec_we), .ec_wdata(ec_wdata), .rot_size(rot_size),
      .gr_log(gr_log), .pr_log(pr_log), .gr_phys(gr_phys), .pr_phys(pr_phys),
      .br_taken(br_taken), .stage_pred(stage_pred)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   int gb = 0, pb = 0, gsz = 96, m_lc = 0, m_ec = 0;
   bit m_stg = 1'b0;

   typedef struct packed {
      logic [15:0] lc;
      logic [5:0]  ec;
      logic [6:0]  sz;
      logic [7:0]  nbr;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{16'd3, 6'd2, 7'd96, 8'd7},
      '{16'd0, 6'd3, 7'd10, 8'd5},
      '{16'd1, 6'd1, 7'd1,  8'd3},
      '{16'd5, 6'd0, 7'd7,  8'd8},
      '{16'd0, 6'd0, 7'd50, 8'd2},
      '{16'd2, 6'd4, 7'd96, 8'd9}
   };

   function automatic int exp_gr(int idx);
      if (gsz != 0 && idx >= 32 && idx < 32 + gsz) return 32 + ((idx - 32 + gb) % gsz);
      return idx;
   endfunction

   function automatic int exp_pr(int idx);
      if (idx >= 64) return 64 + ((idx - 64 + pb) % 64);
      return idx;
   endfunction

   task automatic check(string rq, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic check_map(string rq, int a0, int a1, int p0, int p1);
      gr_log = {7'(a1), 7'(a0)};
      pr_log = {7'(p1), 7'(p0)};
      #1;
      check({rq, " gr0"}, int'(gr_phys[6:0]),  exp_gr(a0));
      check({rq, " gr1"}, int'(gr_phys[13:7]), exp_gr(a1));
      check({rq, " pr0"}, int'(pr_phys[6:0]),  exp_pr(p0));
      check({rq, " pr1"}, int'(pr_phys[13:7]), exp_pr(p1));
   endtask

   task automatic branch(bit lw, int lv, bit ew, int ev);
      bit tk;
      @(negedge clk);
      br_loop = 1'b1;
      lc_we = lw; lc_wdata = 16'(lv);
      ec_we = ew; ec_wdata = 6'(ev);
      #1;
      tk = (m_lc != 0) || (m_ec > 1);
      check("R4/R5/R6 taken", int'(br_taken), int'(tk));
      m_stg = (m_lc != 0);
      if (m_lc != 0) m_lc = m_lc - 1;
      else if (m_ec != 0) m_ec = m_ec - 1;
      if (lw) m_lc = lv;
      if (ew) m_ec = ev;
      if (tk) begin
         if (gsz != 0) gb = (gb + gsz - 1) % gsz;
         pb = (pb + 63) % 64;
      end
      @(negedge clk);
      br_loop = 1'b0; lc_we = 1'b0; ec_we = 1'b0;
      #1;
      check("R4/R5/R6 stage", int'(stage_pred), int'(m_stg));
   endtask

   task automatic set_size(int s);
      @(negedge clk);
      rot_size = 7'(s);
      @(negedge clk);
      gsz = (s > 96) ? 96 : s;
      if (gsz != 0) gb = 0; else gb = 0;
   endtask

   task automatic load(int lv, int ev);
      @(negedge clk);
      lc_we = 1'b1; lc_wdata = 16'(lv);
      ec_we = 1'b1; ec_wdata = 6'(ev);
      @(negedge clk);
      lc_we = 1'b0; ec_we = 1'b0;
      m_lc = lv; m_ec = ev;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      gb = 0; pb = 0; m_lc = 0; m_ec = 0; m_stg = 1'b0;
      gsz = (rot_size > 96) ? 96 : int'(rot_size);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R11: reset state
      #1;
      check("R11 stage after reset", int'(stage_pred), 0);
      check_map("R11 identity after reset", 40, 127, 100, 70);
      branch(0, 0, 0, 0);   // R6: counters zero after reset, not taken
      check_map("R11 no rotation with cleared counters", 33, 90, 64, 127);

      // table walk: R2 R3 R4 R5 R6 R7
      foreach (TBL[k]) begin
         set_size(int'(TBL[k].sz));
         load(int'(TBL[k].lc), int'(TBL[k].ec));
         for (int i = 0; i < int'(TBL[k].nbr); i++) begin
            int a0, a1;
            branch(0, 0, 0, 0);
            a0 = 32 + (i * 7) % gsz;
            a1 = (i % 2 == 1) ? 31 + gsz : ((gsz < 96) ? 32 + gsz : 31);
            check_map("R2/R3/R7 map", a0, a1, 64 + (i * 5) % 64, 63 - i);
         end
      end

      // R7: value written at r found at r+1 after one rotation
      set_size(12);
      load(4, 0);
      begin
         int p_before;
         check_map("R7 before", 35, 43, 70, 127);
         p_before = int'(gr_phys[6:0]);
         branch(0, 0, 0, 0);
         check_map("R7 after", 36, 32, 71, 64);
         check("R7 r to r+1", int'(gr_phys[6:0]), p_before);
      end

      // R9: counter write coincident with a strobe
      load(1, 0);
      branch(1, 3, 0, 0);          // decided on LC=1: taken, then LC=3
      branch(0, 0, 0, 0);
      branch(0, 0, 0, 0);
      branch(0, 0, 0, 0);
      branch(0, 0, 0, 0);          // LC=0, EC=0: not taken
      check_map("R9 bases", 40, 43, 99, 5);
      load(0, 3);
      branch(0, 0, 1, 0);          // EC=3 drain taken, written 0 wins
      branch(0, 0, 0, 0);          // not taken
      check_map("R9 ec write", 33, 41, 64, 1);

      // R10: size change clears general base, predicate base kept
      load(3, 0);
      branch(0, 0, 0, 0);
      branch(0, 0, 0, 0);
      set_size(20);
      check_map("R10 resize", 32, 51, 64, 127);
      check("R10 base cleared", int'(gr_phys[6:0]), 32);

      // R2: clamp above 96 and size 0
      set_size(127);
      load(1, 0);
      branch(0, 0, 0, 0);
      check_map("R2 clamp", 127, 32, 80, 20);
      check("R2 clamp top", int'(gr_phys[6:0]), 126);
      set_size(0);
      load(2, 0);
      branch(0, 0, 0, 0);
      check_map("R2 size zero", 32, 127, 64, 0);
      check("R2 size zero pass", int'(gr_phys[13:7]), 127);

      // R1: low indices untouched after rotations
      set_size(96);
      load(2, 0);
      branch(0, 0, 0, 0);
      check_map("R1 low pass", 0, 31, 0, 63);

      // R8: no strobe, no taken even with counters loaded
      load(5, 5);
      #1;
      check("R8 idle taken", int'(br_taken), 0);

      // R11: mid-loop reset
      branch(0, 0, 0, 0);
      do_reset();
      #1;
      check("R11 stage cleared", int'(stage_pred), 0);
      check_map("R11 bases cleared", 50, 100, 90, 127);
      branch(0, 0, 0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule